// File: doc/BRIEF.md
# Instruction-Side Micro Translation Cache

This block is a two-slot, fully associative translation cache that sits on the instruction-fetch path. It is placed in front of a larger shared translation table. Each cycle the fetch unit presents a 4KB virtual page number together with the current address space identifier. On a hit, the block returns the 4KB physical frame and the cache attribute field in the same cycle, without combining its lookup with any data-side translation. Software has no read or write access to the slots.

On a miss, the block asserts stall at once. From the next cycle it raises a refill request that carries the missing page number and identifier, and it keeps that request up until the shared table answers. The answer is written into a free slot if one exists, and otherwise into the least recently used slot. When the answering mapping covers more than 4KB, the frame stored in the slot is narrowed to the single 4KB frame that the requested page falls in. Any write to the shared table, or any change of the current identifier, empties both slots and cancels an outstanding request.

Top module: `instr_utlb`

## Requirements
- R1: After reset both slots are empty and no request is pending, so hit, stall and refill_req are all 0 while lookup_valid is low.
- R2: When lookup_valid is high and a valid slot holds a page number equal to lookup_vpn and a matching identifier, hit is 1 in that same cycle and hit_frame and hit_attr show that slot's frame and attribute. When hit is 0, hit_frame and hit_attr read 0.
- R3: A slot filled with refill_global=1 ignores the identifier comparison. In the cycle where cur_asid has just changed, such a slot still hits, while a non-global slot does not hit.
- R4: A lookup that misses drives stall=1 in that cycle. If no request is outstanding, refill_req rises on the next cycle with refill_vpn and refill_asid equal to the missing page number and identifier. The request is then held unchanged until refill_valid is sampled high.
- R5: At the clock edge where refill_valid is high with a request outstanding, the slot is written and the request drops. The stored frame is refill_pfn with each bit i below 12 where refill_mask[i]=1 replaced by bit i of the requested page number. The same lookup hits on the following cycle.
- R6: The refill target is slot 0 if slot 0 is empty, otherwise slot 1 if slot 1 is empty, otherwise the least recently used slot. A hit or a fill on one slot makes the other slot the next target.
- R7: A cycle with jtlb_write=1 empties both slots at its clock edge. If a request is outstanding, it is cancelled: refill_req is 0 on the next cycle and no slot is written in that cycle.
- R8: A cycle in which cur_asid differs from its value in the previous cycle empties both slots and cancels an outstanding request in the same way as R7. The first cycle after reset compares against an identifier of 0.
- R9: refill_valid has no effect when no request is outstanding. No slot changes, and a later lookup of that page still misses.
- R10: At most one slot matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_valid | input | 1 | A fetch translation is requested this cycle |
| lookup_vpn | input | 20 | 4KB virtual page number to translate |
| cur_asid | input | 8 | Current address space identifier |
| jtlb_write | input | 1 | The shared table is being written; flush |
| hit | output | 1 | Lookup found a matching slot |
| hit_frame | output | 24 | 4KB physical frame of the hit (0 on miss) |
| hit_attr | output | 3 | Cache attribute of the hit (0 on miss) |
| stall | output | 1 | Lookup requested and not translated |
| refill_req | output | 1 | Refill request to the shared table |
| refill_vpn | output | 20 | Page number being refilled |
| refill_asid | output | 8 | Identifier being refilled |
| refill_valid | input | 1 | Shared table answers the request |
| refill_pfn | input | 24 | Frame number returned |
| refill_mask | input | 12 | Page-size mask in 4KB units (1 = bit comes from page number) |
| refill_global | input | 1 | Returned mapping ignores the identifier |
| refill_attr | input | 3 | Cache attribute returned |

## Verification
The embedded properties check on every cycle that at most one slot matches. They also check that an open request stays up with a stable page number until it is answered or cancelled, that a flush leaves both slots empty and drops the request, that a fill lands in a valid slot, and that the replacement target moves away from a slot just hit. Only the bench scenarios can show the ones that depend on data values: the frame narrowing for large pages, the exact victim order across a series of fills, the one-cycle window in which a global slot survives an identifier change, and whether a stray refill answer is ignored. These are judged against a behavioural model that is compared with the design every cycle.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  parameter int VPN_W   = 20;
  parameter int ASID_W  = 8;
  parameter int PFN_W   = 24;
  parameter int MASK_W  = 12;
  parameter int ATTR_W  = 3;
  parameter int ENTRIES = 2;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef struct packed {
    logic              valid;
    logic              glob;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PFN_W-1:0]  pfn;
    logic [ATTR_W-1:0] attr;
  } slot_t;

  // Narrow a large-page frame to the 4KB frame holding the page number.
  function automatic logic [PFN_W-1:0] frame_4k(
    input logic [PFN_W-1:0]  pfn,
    input logic [VPN_W-1:0]  vpn,
    input logic [MASK_W-1:0] mask
  );
    logic [PFN_W-1:0] m;
    logic [PFN_W-1:0] low;
    m   = PFN_W'(mask);
    low = PFN_W'(vpn[MASK_W-1:0]) & m;
    return (pfn & ~m) | low;
  endfunction

  function automatic logic tag_hit(
    input slot_t             s,
    input logic [VPN_W-1:0]  vpn,
    input logic [ASID_W-1:0] asid
  );
    return s.valid && (s.vpn == vpn) && (s.glob || (s.asid == asid));
  endfunction
endpackage

// File: rtl/utlb_match.sv
module utlb_match
  import utlb_pkg::*;
(
  input  slot_t             slot,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  output logic              match
);
  assign match = tag_hit(slot, vpn, asid);
endmodule

// File: rtl/utlb_lru.sv
module utlb_lru
  import utlb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_any,
  input  logic [IDX_W-1:0]   hit_idx,
  input  logic               fill_fire,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lru_q <= '0;
    else if (fill_fire) lru_q <= ~fill_idx;
    else if (hit_any)   lru_q <= ~hit_idx;
  end

  // Free slots first, lowest index wins; otherwise the least recently used.
  always_comb begin
    victim = lru_q;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) victim = IDX_W'(i);
    end
  end

  assert_lru_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_any && !fill_fire) |=> (!(&valid_vec) || (victim != $past(hit_idx))));
endmodule

// File: rtl/utlb_refill.sv
module utlb_refill
  import utlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss,
  input  logic              flush,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  output logic              req,
  output logic [VPN_W-1:0]  req_vpn,
  output logic [ASID_W-1:0] req_asid,
  output logic              fill_fire
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e st_q;

  assign req       = (st_q == ST_WAIT);
  assign fill_fire = req && fill_valid && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      req_vpn  <= '0;
      req_asid <= '0;
    end else if (st_q == ST_WAIT) begin
      if (flush || fill_valid) st_q <= ST_IDLE;
    end else if (miss) begin
      st_q     <= ST_WAIT;
      req_vpn  <= vpn;
      req_asid <= asid;
    end
  end

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !fill_valid && !flush) |=> (req && $stable(req_vpn) && $stable(req_asid)));
  assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> !req);
  assert_req_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && flush) |=> !req);
endmodule

// File: rtl/instr_utlb.sv
module instr_utlb
  import utlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookup_valid,
  input  logic [VPN_W-1:0]  lookup_vpn,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              jtlb_write,
  output logic              hit,
  output logic [PFN_W-1:0]  hit_frame,
  output logic [ATTR_W-1:0] hit_attr,
  output logic              stall,
  output logic              refill_req,
  output logic [VPN_W-1:0]  refill_vpn,
  output logic [ASID_W-1:0] refill_asid,
  input  logic              refill_valid,
  input  logic [PFN_W-1:0]  refill_pfn,
  input  logic [MASK_W-1:0] refill_mask,
  input  logic              refill_global,
  input  logic [ATTR_W-1:0] refill_attr
);
  slot_t              slot_q [ENTRIES];
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [ASID_W-1:0]  asid_q;
  logic               asid_chg;
  logic               flush;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim;
  logic               fill_fire;
  logic               miss;
  slot_t              new_slot;

  // Identifier tracking: a change flushes at the end of the cycle it appears.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) asid_q <= '0;
    else        asid_q <= cur_asid;
  end
  assign asid_chg = (cur_asid != asid_q);
  assign flush    = jtlb_write || asid_chg;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    utlb_match u_match (
      .slot  (slot_q[g]),
      .vpn   (lookup_vpn),
      .asid  (cur_asid),
      .match (match_vec[g])
    );
    assign valid_vec[g] = slot_q[g].valid;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   slot_q[g] <= '0;
      else if (flush)                               slot_q[g].valid <= 1'b0;
      else if (fill_fire && (victim == IDX_W'(g)))  slot_q[g] <= new_slot;
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit_any   = lookup_valid && (|match_vec);
  assign miss      = lookup_valid && !hit_any;
  assign hit       = hit_any;
  assign stall     = miss;
  assign hit_frame = hit_any ? slot_q[hit_idx].pfn  : '0;
  assign hit_attr  = hit_any ? slot_q[hit_idx].attr : '0;

  always_comb begin
    new_slot.valid = 1'b1;
    new_slot.glob  = refill_global;
    new_slot.vpn   = refill_vpn;
    new_slot.asid  = refill_asid;
    new_slot.pfn   = frame_4k(refill_pfn, refill_vpn, refill_mask);
    new_slot.attr  = refill_attr;
  end

  utlb_refill u_refill (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss       (miss),
    .flush      (flush),
    .fill_valid (refill_valid),
    .vpn        (lookup_vpn),
    .asid       (cur_asid),
    .req        (refill_req),
    .req_vpn    (refill_vpn),
    .req_asid   (refill_asid),
    .fill_fire  (fill_fire)
  );

  utlb_lru u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_any   (hit_any),
    .hit_idx   (hit_idx),
    .fill_fire (fill_fire),
    .fill_idx  (victim),
    .valid_vec (valid_vec),
    .victim    (victim)
  );

  assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));
  assert_fill_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> (valid_vec != '0));
  assert_asid_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_asid != asid_q) |=> !refill_req || $past(!refill_req));
endmodule

// File: tb/test_instr_utlb.sv
module test_instr_utlb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        lookup_valid = 0;
  logic [19:0] lookup_vpn = 0;
  logic [7:0]  cur_asid = 0;
  logic        jtlb_write = 0;
  logic        hit, stall, refill_req;
  logic [23:0] hit_frame;
  logic [2:0]  hit_attr;
  logic [19:0] refill_vpn;
  logic [7:0]  refill_asid;
  logic        refill_valid = 0;
  logic [23:0] refill_pfn = 0;
  logic [11:0] refill_mask = 0;
  logic        refill_global = 0;
  logic [2:0]  refill_attr = 0;

  int    n_run = 0;
  int    n_fail = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  instr_utlb i_instr_utlb (.*);

  // Behavioural reference model
  bit          m_v [2];
  bit          m_g [2];
  int          m_vpn [2];
  int          m_asid [2];
  int          m_frame [2];
  int          m_attr [2];
  int          m_lru, m_prev_asid, m_rvpn, m_rasid, m_hi, m_vic;
  bit          m_wait, m_fl;

  function automatic int m_find();
    for (int i = 0; i < 2; i++)
      if (lookup_valid && m_v[i] && m_vpn[i] == lookup_vpn &&
          (m_g[i] || m_asid[i] == cur_asid)) return i;
    return -1;
  endfunction

  function automatic int narrow(int pfn, int vpn, int mask);
    int r = pfn;
    for (int b = 0; b < 12; b++)
      if (mask[b]) r[b] = vpn[b];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_lru = 0; m_prev_asid = 0; m_wait = 0; m_rvpn = 0; m_rasid = 0;
    end else begin
      m_fl = jtlb_write || (cur_asid != m_prev_asid);
      m_prev_asid = cur_asid;
      m_hi = m_find();
      if (m_hi >= 0) m_lru = 1 - m_hi;
      if (m_wait) begin
        if (m_fl) m_wait = 0;
        else if (refill_valid) begin
          m_vic = !m_v[0] ? 0 : (!m_v[1] ? 1 : m_lru);
          m_v[m_vic] = 1; m_g[m_vic] = refill_global;
          m_vpn[m_vic] = m_rvpn; m_asid[m_vic] = m_rasid;
          m_frame[m_vic] = narrow(refill_pfn, m_rvpn, refill_mask);
          m_attr[m_vic] = refill_attr;
          m_lru = 1 - m_vic; m_wait = 0;
        end
      end else if (lookup_valid && m_hi < 0) begin
        m_wait = 1; m_rvpn = lookup_vpn; m_rasid = cur_asid;
      end
      if (m_fl) begin m_v[0] = 0; m_v[1] = 0; end
    end
  end

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Compare all outputs with the model, then advance to the next negedge.
  task automatic tick();
    int          h;
    logic [63:0] e, a;
    #1;
    h = m_find();
    e = {6'd0, (h >= 0), (h >= 0) ? 24'(m_frame[h]) : 24'd0,
         (h >= 0) ? 3'(m_attr[h]) : 3'd0, (lookup_valid && h < 0), m_wait,
         m_wait ? 20'(m_rvpn) : 20'd0, m_wait ? 8'(m_rasid) : 8'd0};
    a = {6'd0, hit, hit_frame, hit_attr, stall, refill_req,
         refill_req ? refill_vpn : 20'd0, refill_req ? refill_asid : 8'd0};
    check(phase, a, e);
    @(negedge clk);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] asid,
                      input logic [23:0] pfn, input logic [11:0] mask,
                      input logic g, input logic [2:0] attr, input int waits);
    lookup_valid = 1; lookup_vpn = vpn; cur_asid = asid;
    tick();
    for (int k = 0; k < waits; k++) tick();
    refill_valid = 1; refill_pfn = pfn; refill_mask = mask;
    refill_global = g; refill_attr = attr;
    tick();
    refill_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1";
    tick();
    check("R1", {61'd0, hit, stall, refill_req}, 64'd0);
    tick();

    phase = "R4";
    lookup_valid = 1; lookup_vpn = 20'h12345; cur_asid = 8'h05;
    tick();                       // asid change from 0: flush cycle, miss starts request
    check("R4", {63'd0, refill_req}, 64'd1);
    tick(); tick();
    phase = "R5";
    refill_valid = 1; refill_pfn = 24'h0ABCDE; refill_mask = 12'h0FF; refill_attr = 3'd3;
    tick();
    refill_valid = 0;
    check("R5", {39'd0, hit, hit_frame}, {39'd0, 1'b1, 24'h0ABC45});
    tick();

    phase = "R2";
    fill(20'h00AAA, 8'h05, 24'h111000, 12'h000, 0, 3'd2, 1);
    check("R2", {36'd0, hit, hit_frame, hit_attr}, {36'd0, 1'b1, 24'h111000, 3'd2});
    tick();

    phase = "R6";
    lookup_vpn = 20'h12345; tick();                  // hit slot 0 -> slot 1 is victim
    fill(20'h00BBB, 8'h05, 24'h222000, 12'h000, 0, 3'd1, 0);
    tick();
    lookup_vpn = 20'h00AAA; tick();                  // replaced: must miss
    check("R6", {63'd0, hit}, 64'd0);
    lookup_valid = 0; tick(); tick(); tick();
    lookup_valid = 1; lookup_vpn = 20'h12345; tick();
    check("R6", {63'd0, hit}, 64'd1);

    phase = "R9";
    lookup_valid = 0;
    refill_valid = 1; refill_pfn = 24'h333000; tick();
    refill_valid = 0; tick();
    lookup_valid = 1; lookup_vpn = 20'h00CCC; tick();
    check("R9", {63'd0, hit}, 64'd0);
    lookup_valid = 0; tick(); tick();

    phase = "R7";
    jtlb_write = 1; tick(); jtlb_write = 0;
    lookup_valid = 1; lookup_vpn = 20'h12345; tick();
    check("R7", {63'd0, hit}, 64'd0);
    tick();
    jtlb_write = 1; tick(); jtlb_write = 0;          // cancels outstanding request
    lookup_valid = 0;
    check("R7", {63'd0, refill_req}, 64'd0);
    refill_valid = 1; refill_pfn = 24'h444000; tick(); refill_valid = 0;
    lookup_valid = 1; tick();
    check("R7", {63'd0, hit}, 64'd0);
    lookup_valid = 0; tick(); tick();

    phase = "R3";
    fill(20'h00777, 8'h09, 24'h555000, 12'h000, 1, 3'd4, 0);
    tick();
    fill(20'h00888, 8'h09, 24'h666000, 12'h000, 0, 3'd5, 0);
    tick();
    lookup_vpn = 20'h00777; cur_asid = 8'h0A; tick();
    lookup_vpn = 20'h00777; cur_asid = 8'h0A;
    check("R3", {63'd0, hit}, 64'd0);                // flushed at previous edge
    lookup_valid = 0; tick(); tick();

    phase = "R8";
    fill(20'h00888, 8'h0A, 24'h777000, 12'h000, 0, 3'd6, 2);
    check("R8", {63'd0, hit}, 64'd1);
    cur_asid = 8'h0B; tick();
    check("R8", {63'd0, hit}, 64'd0);
    cur_asid = 8'h0A; tick();
    check("R8", {63'd0, hit}, 64'd0);
    lookup_valid = 0; tick(); tick();

    phase = "R3";
    fill(20'h00321, 8'h0A, 24'h888000, 12'h000, 1, 3'd7, 0);
    cur_asid = 8'h0C;                                // change-cycle: global slot hits
    #1 check("R3", {63'd0, hit}, 64'd1);
    tick();
    #1 check("R3", {63'd0, hit}, 64'd0);
    lookup_valid = 0; tick(); tick();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule